// File: doc/BRIEF.md
# SD Card Command Issue Engine

This block runs the command phase of an SD card link. Software loads a 32-bit argument and then writes a command word that carries a 6-bit index, a response-type field and a self-clearing launch flag. The engine then shifts a 48-bit frame, protected by CRC7, onto the command line. It releases the line and collects the card's reply. Depending on the response type, the reply is nothing, a 48-bit frame or a 136-bit frame. When the short reply is followed by a busy period, the engine also waits until the card lets DAT0 go high again.

Completion is seen in the command word: the launch flag drops to zero, and a sticky failure flag reports whether the command ended badly. The status word records a missing response, a response CRC mismatch and the end of a busy period. Software clears each of these flags by writing a one to it. The card clock is derived from the system clock by a divider that is programmed as divisor minus two. A configuration word holds the bus-width and slow-card selections and gates the interrupt raised when a busy period ends.

Register word addresses: 0 command, 1 argument, 2 divider, 3 to 6 response words 0 to 3, 7 status, 8 configuration.

Top module: `sdcmd_engine`

## Requirements
- R1: After reset the command, argument, status, configuration and response words read 0, the divider reads 0x7FF, the command line is not driven and cmd_out is 1.
- R2: With divider value D, card_clk has a period of D+2 system clocks: it is low for floor((D+2)/2) clocks and high for the remaining clocks.
- R3: Writing the command word with bit 15 set while idle sends the frame MSB first: 0, 1, index (word bits 5:0), argument, CRC7, 1. cmd_oe is high exactly for these 48 bits, and cmd_out and cmd_oe change only where card_clk falls.
- R4: The CRC7 in sent frames uses the polynomial x^7+x^3+1 with a zero initial value, taken over the first 40 frame bits.
- R5: Bit 15 stays set until the command finishes and then reads 0. While bit 15 is set, writes to the command and argument words have no effect. Bits 7 and 6 (direction marks) and bits 11:9 read back as written.
- R6: Field 11:9 selects the response: 0 gives a 48-bit response, 1 gives a 136-bit response, 2 gives no response, 4 gives a 48-bit response followed by busy. Any other value behaves as no response.
- R7: For a 48-bit response, its 32 payload bits (frame bits 39:8) go to response word 0. If its CRC7 does not match, status bit 4 and command bit 14 are set.
- R8: For a 136-bit response, the 128 bits after the first 8 are stored without a CRC check. Response word 3 holds the most significant 32 of them and word 0 the least significant.
- R9: If the card keeps the command line high for 64 card-clock samples after the frame, status bit 6 and command bit 14 are set and the command ends. A start bit seen on the 64th sample is accepted.
- R10: For type 4, completion waits until DAT0 is sampled high. Status bit 10 is then set, and irq is high exactly while status bit 10 and configuration bit 10 are both set.
- R11: Writing a one to status bit 10, 6 or 4 clears that bit. Writing a zero leaves it unchanged.
- R12: Configuration bit 2 drives bus_4bit and bit 3 drives slow_card. A new launch clears command bit 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| card_clk | output | 1 | Card clock |
| cmd_out | output | 1 | Command line value driven by the host |
| cmd_oe | output | 1 | Command line drive enable |
| cmd_in | input | 1 | Command line value seen from the card |
| dat0_in | input | 1 | DAT0 line, low while the card is busy |
| bus_4bit | output | 1 | Four-bit data bus selection |
| slow_card | output | 1 | Slow-card mode selection |
| irq | output | 1 | Busy-end interrupt |

## Verification
The bench places the response start bit on the last sample before the timeout. An off-by-one in the timeout counter would then fail a good command or wait one sample too long. It sends a short reply with one CRC bit flipped, which a design that skipped or misaligned the CRC check would accept. It also sends a long reply whose words differ, so a reversed or shifted word order shows up in the response registers. During a busy period it holds DAT0 low and writes a new command over the one in flight. A design that finished early, or that let a busy engine accept a launch, would change the status, the argument or the index that the bench reads back. Type 3 is sent with no reply: a design that treated it as a short response would report a timeout.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
   localparam int unsigned ADDR_W   = 4;
   localparam int unsigned CMD_LEN  = 48;
   localparam int unsigned SHRT_LEN = 48;
   localparam int unsigned LONG_LEN = 136;
   localparam int unsigned RX_W     = 128;

   localparam logic [ADDR_W-1:0] A_CMD  = 4'd0;
   localparam logic [ADDR_W-1:0] A_ARG  = 4'd1;
   localparam logic [ADDR_W-1:0] A_DIV  = 4'd2;
   localparam logic [ADDR_W-1:0] A_RSP0 = 4'd3;
   localparam logic [ADDR_W-1:0] A_RSP3 = 4'd6;
   localparam logic [ADDR_W-1:0] A_STAT = 4'd7;
   localparam logic [ADDR_W-1:0] A_CFG  = 4'd8;

   localparam int unsigned CB_GO    = 15;
   localparam int unsigned CB_FAIL  = 14;
   localparam int unsigned SB_BUSY  = 10;
   localparam int unsigned SB_NORSP = 6;
   localparam int unsigned SB_CRC   = 4;
   localparam int unsigned GB_IRQEN = 10;
   localparam int unsigned GB_SLOW  = 3;
   localparam int unsigned GB_WIDE  = 2;

   typedef enum logic [2:0] {
      ST_IDLE, ST_SEND, ST_LISTEN, ST_RECV, ST_FINAL, ST_HOLD
   } eng_state_t;

   typedef enum logic [1:0] {
      RK_NONE, RK_SHORT, RK_LONG, RK_SHORT_BUSY
   } rsp_kind_t;

   function automatic rsp_kind_t decode_kind(input logic [2:0] f);
      case (f)
         3'd0:    decode_kind = RK_SHORT;
         3'd1:    decode_kind = RK_LONG;
         3'd4:    decode_kind = RK_SHORT_BUSY;
         default: decode_kind = RK_NONE;
      endcase
   endfunction
endpackage

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7 #(
   parameter int unsigned LEN = 40
) (
   input  logic [LEN-1:0] bits_i,
   output logic [6:0]     crc_o
);
   if (LEN < 1) begin : g_bad_len
      $error("sdcmd_crc7: LEN must be positive");
   end

   always_comb begin
      logic [6:0] acc;
      logic       fb;
      acc = '0;
      for (int i = LEN - 1; i >= 0; i--) begin
         fb  = bits_i[i] ^ acc[6];
         acc = {acc[5:0], 1'b0};
         if (fb) acc = acc ^ 7'h09;
      end
      crc_o = acc;
   end
endmodule

// File: rtl/sdcmd_clkgen.sv
module sdcmd_clkgen #(
   parameter int unsigned DIV_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_i,
   output logic             sclk_o,
   output logic             fall_tick_o,
   output logic             rise_tick_o
);
   localparam int unsigned CW = DIV_W + 1;

   logic [CW-1:0] period, half, cnt;

   assign period      = {1'b0, div_i} + CW'(2);
   assign half        = period >> 1;
   assign fall_tick_o = (cnt >= period - CW'(1));
   assign rise_tick_o = !fall_tick_o && (cnt == half - CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         sclk_o <= 1'b0;
      end else if (fall_tick_o) begin
         cnt    <= '0;
         sclk_o <= 1'b0;
      end else begin
         cnt <= cnt + CW'(1);
         if (rise_tick_o) sclk_o <= 1'b1;
      end
   end
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
   import sdcmd_pkg::*;
#(
   parameter int unsigned DIV_W        = 11,
   parameter int unsigned RESP_TIMEOUT = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              card_clk,
   output logic              cmd_out,
   output logic              cmd_oe,
   input  logic              cmd_in,
   input  logic              dat0_in,
   output logic              bus_4bit,
   output logic              slow_card,
   output logic              irq
);
   localparam int unsigned TO_W = $clog2(RESP_TIMEOUT);

   if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
      $error("sdcmd_engine: DIV_W out of range");
   end
   if (RESP_TIMEOUT < 2) begin : g_bad_to
      $error("sdcmd_engine: RESP_TIMEOUT too small");
   end

   logic [5:0]       cmd_idx;
   logic [1:0]       cmd_dir;
   logic [2:0]       rtype;
   logic             start_q, fail_q;
   logic [31:0]      arg_q;
   logic [DIV_W-1:0] div_q;
   logic [3:0][31:0] resp_q;
   logic             stat_busy, stat_norsp, stat_crc;
   logic             cfg_irqen, cfg_slow, cfg_wide;
   eng_state_t       state;
   rsp_kind_t        kind;
   logic [7:0]       bitcnt;
   logic [TO_W-1:0]  tcnt;
   logic [RX_W-1:0]  rx_sr;
   logic             fall_tick, rise_tick;
   logic [6:0]       tx_crc, rx_crc;
   logic [CMD_LEN-1:0] frame;
   logic [5:0]       tx_pos;
   logic [7:0]       rx_last;

   sdcmd_clkgen #(.DIV_W(DIV_W)) u_clk (
      .clk(clk), .rst_n(rst_n), .div_i(div_q),
      .sclk_o(card_clk), .fall_tick_o(fall_tick), .rise_tick_o(rise_tick)
   );

   sdcmd_crc7 #(.LEN(40)) u_crc_tx (.bits_i({2'b01, cmd_idx, arg_q}), .crc_o(tx_crc));
   sdcmd_crc7 #(.LEN(40)) u_crc_rx (.bits_i(rx_sr[47:8]), .crc_o(rx_crc));

   assign frame   = {2'b01, cmd_idx, arg_q, tx_crc, 1'b1};
   assign tx_pos  = 6'(CMD_LEN - 1) - bitcnt[5:0];
   assign rx_last = (kind == RK_LONG) ? 8'(LONG_LEN - 1) : 8'(SHRT_LEN - 1);

   assign bus_4bit  = cfg_wide;
   assign slow_card = cfg_slow;
   assign irq       = stat_busy & cfg_irqen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_idx <= '0; cmd_dir <= '0; rtype <= '0;
         start_q <= 1'b0; fail_q <= 1'b0;
         arg_q <= '0; div_q <= '1; resp_q <= '0;
         stat_busy <= 1'b0; stat_norsp <= 1'b0; stat_crc <= 1'b0;
         cfg_irqen <= 1'b0; cfg_slow <= 1'b0; cfg_wide <= 1'b0;
         state <= ST_IDLE; kind <= RK_NONE;
         bitcnt <= '0; tcnt <= '0; rx_sr <= '0;
         cmd_out <= 1'b1; cmd_oe <= 1'b0;
      end else begin
         if (reg_we) begin
            case (reg_addr)
               A_CMD: if (!start_q) begin
                  cmd_idx <= reg_wdata[5:0];
                  cmd_dir <= reg_wdata[7:6];
                  rtype   <= reg_wdata[11:9];
                  fail_q  <= 1'b0;
                  start_q <= reg_wdata[CB_GO];
                  if (reg_wdata[CB_GO]) begin
                     kind   <= decode_kind(reg_wdata[11:9]);
                     bitcnt <= '0;
                     state  <= ST_SEND;
                  end
               end
               A_ARG: if (!start_q) arg_q <= reg_wdata;
               A_DIV: div_q <= reg_wdata[DIV_W-1:0];
               A_STAT: begin
                  if (reg_wdata[SB_BUSY])  stat_busy  <= 1'b0;
                  if (reg_wdata[SB_NORSP]) stat_norsp <= 1'b0;
                  if (reg_wdata[SB_CRC])   stat_crc   <= 1'b0;
               end
               A_CFG: begin
                  cfg_irqen <= reg_wdata[GB_IRQEN];
                  cfg_slow  <= reg_wdata[GB_SLOW];
                  cfg_wide  <= reg_wdata[GB_WIDE];
               end
               default: ;
            endcase
         end

         case (state)
            ST_SEND: if (fall_tick) begin
               if (bitcnt < 8'(CMD_LEN)) begin
                  cmd_oe  <= 1'b1;
                  cmd_out <= frame[tx_pos];
                  bitcnt  <= bitcnt + 8'd1;
               end else begin
                  cmd_oe  <= 1'b0;
                  cmd_out <= 1'b1;
                  tcnt    <= '0;
                  if (kind == RK_NONE) begin
                     start_q <= 1'b0;
                     state   <= ST_IDLE;
                  end else begin
                     state <= ST_LISTEN;
                  end
               end
            end
            ST_LISTEN: if (rise_tick) begin
               if (!cmd_in) begin
                  rx_sr  <= {rx_sr[RX_W-2:0], 1'b0};
                  bitcnt <= 8'd1;
                  state  <= ST_RECV;
               end else if (tcnt == TO_W'(RESP_TIMEOUT - 1)) begin
                  stat_norsp <= 1'b1;
                  fail_q     <= 1'b1;
                  start_q    <= 1'b0;
                  state      <= ST_IDLE;
               end else begin
                  tcnt <= tcnt + TO_W'(1);
               end
            end
            ST_RECV: if (rise_tick) begin
               rx_sr  <= {rx_sr[RX_W-2:0], cmd_in};
               bitcnt <= bitcnt + 8'd1;
               if (bitcnt == rx_last) state <= ST_FINAL;
            end
            ST_FINAL: begin
               if (kind == RK_LONG) begin
                  resp_q  <= rx_sr;
                  start_q <= 1'b0;
                  state   <= ST_IDLE;
               end else begin
                  resp_q[0] <= rx_sr[39:8];
                  if (rx_crc != rx_sr[7:1]) begin
                     stat_crc <= 1'b1;
                     fail_q   <= 1'b1;
                  end
                  if (kind == RK_SHORT_BUSY) begin
                     state <= ST_HOLD;
                  end else begin
                     start_q <= 1'b0;
                     state   <= ST_IDLE;
                  end
               end
            end
            ST_HOLD: if (rise_tick && dat0_in) begin
               stat_busy <= 1'b1;
               start_q   <= 1'b0;
               state     <= ST_IDLE;
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CMD: begin
            reg_rdata[CB_GO]   = start_q;
            reg_rdata[CB_FAIL] = fail_q;
            reg_rdata[11:9]    = rtype;
            reg_rdata[7:6]     = cmd_dir;
            reg_rdata[5:0]     = cmd_idx;
         end
         A_ARG: reg_rdata = arg_q;
         A_DIV: reg_rdata[DIV_W-1:0] = div_q;
         A_STAT: begin
            reg_rdata[SB_BUSY]  = stat_busy;
            reg_rdata[SB_NORSP] = stat_norsp;
            reg_rdata[SB_CRC]   = stat_crc;
         end
         A_CFG: begin
            reg_rdata[GB_IRQEN] = cfg_irqen;
            reg_rdata[GB_SLOW]  = cfg_slow;
            reg_rdata[GB_WIDE]  = cfg_wide;
         end
         default:
            if (reg_addr >= A_RSP0 && reg_addr <= A_RSP3)
               reg_rdata = resp_q[2'(reg_addr - A_RSP0)];
      endcase
   end
endmodule

// File: rtl/sdcmd_engine_chk.sv
module sdcmd_engine_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       card_clk,
   input logic       cmd_oe,
   input logic       cmd_out,
   input logic       start_q,
   input logic       fail_q,
   input logic       stat_norsp,
   input logic       stat_busy,
   input logic [2:0] rtype
);
   assert_frame_opens_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_oe) |-> !cmd_out);

   assert_frame_closes_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cmd_oe) |-> $past(cmd_out));

   assert_drive_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cmd_oe) |-> $fell(card_clk));

   assert_drive_needs_go_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_oe |-> start_q);

   assert_go_drop_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(start_q) |-> !cmd_oe);

   assert_noresp_marks_fail_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_norsp) |-> (fail_q && !start_q));

   assert_busy_flag_type_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_busy) |-> (rtype == 3'd4));
endmodule

bind sdcmd_engine sdcmd_engine_chk u_chk (
   .clk(clk), .rst_n(rst_n), .card_clk(card_clk), .cmd_oe(cmd_oe),
   .cmd_out(cmd_out), .start_q(start_q), .fail_q(fail_q),
   .stat_norsp(stat_norsp), .stat_busy(stat_busy), .rtype(rtype)
);

// File: tb/sdcmd_engine_tb.sv
module sdcmd_engine_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        card_clk, cmd_out, cmd_oe, bus_4bit, slow_card, irq;
   logic        cmd_in = 1'b1;
   logic        dat0_in = 1'b1;

   int nchk = 0;
   int nfail = 0;

   always #2 clk = ~clk;

   sdcmd_engine u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .card_clk(card_clk),
      .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_in(cmd_in), .dat0_in(dat0_in),
      .bus_4bit(bus_4bit), .slow_card(slow_card), .irq(irq)
   );

   task automatic chk(input string tag, input logic [135:0] act, input logic [135:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   function automatic logic [6:0] crc7(input logic [39:0] d);
      logic [6:0] c = '0;
      for (int i = 39; i >= 0; i--) begin
         logic f = d[i] ^ c[6];
         c = {c[5:0], 1'b0} ^ (f ? 7'h09 : 7'h00);
      end
      return c;
   endfunction

   function automatic logic [47:0] cmd_frame(input logic [5:0] idx, input logic [31:0] arg);
      return {2'b01, idx, arg, crc7({2'b01, idx, arg}), 1'b1};
   endfunction

   function automatic logic [47:0] short_rsp(input logic [5:0] idx, input logic [31:0] pl);
      return {2'b00, idx, pl, crc7({2'b00, idx, pl}), 1'b1};
   endfunction

   task automatic exchange(input logic [31:0] cw, input logic [31:0] arg,
                           input bit respond, input int dly, input int rlen,
                           input logic [135:0] rsp, output logic [47:0] fr);
      int n = 0;
      fr = '0;
      wr(4'd1, arg);
      wr(4'd0, cw);
      while (n < 48) begin
         @(posedge card_clk);
         if (cmd_oe) begin
            fr[47-n] = cmd_out;
            n++;
         end
      end
      if (respond) begin
         repeat (dly) begin
            @(negedge card_clk);
            cmd_in = 1'b1;
         end
         for (int i = 0; i < rlen; i++) begin
            @(negedge card_clk);
            cmd_in = rsp[rlen-1-i];
         end
         @(negedge card_clk);
         cmd_in = 1'b1;
      end
   endtask

   task automatic wait_done();
      logic [31:0] d;
      for (int k = 0; k < 4000; k++) begin
         rd(4'd0, d);
         if (!d[15]) break;
      end
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(4'd0, d); chk("R1 cmd word", d, 0);
      rd(4'd1, d); chk("R1 arg word", d, 0);
      rd(4'd2, d); chk("R1 divider", d, 32'h7FF);
      rd(4'd3, d); chk("R1 resp0", d, 0);
      rd(4'd7, d); chk("R1 status", d, 0);
      rd(4'd8, d); chk("R1 config", d, 0);
      chk("R1 cmd_oe/cmd_out", {cmd_oe, cmd_out}, 2'b01);
   endtask

   task automatic t_clock();
      time t0, t1, t2;
      wr(4'd2, 32'd3);
      repeat (3) @(posedge card_clk);
      t0 = $time; @(negedge card_clk); t1 = $time; @(posedge card_clk); t2 = $time;
      chk("R2 high D=3", (t1 - t0) / 4, 3);
      chk("R2 low D=3", (t2 - t1) / 4, 2);
      wr(4'd2, 32'd0);
      repeat (3) @(posedge card_clk);
      t0 = $time; @(negedge card_clk); t1 = $time; @(posedge card_clk); t2 = $time;
      chk("R2 high D=0", (t1 - t0) / 4, 1);
      chk("R2 low D=0", (t2 - t1) / 4, 1);
   endtask

   task automatic t_short();
      logic [47:0] fr;
      logic [31:0] d;
      logic [31:0] cw = 32'h8000 | (32'd1 << 6) | 32'd17;
      exchange(cw, 32'h12345678, 1, 5, 48, {88'b0, short_rsp(6'd17, 32'hCAFEF00D)}, fr);
      wait_done();
      chk("R3 R4 frame cmd17", fr, cmd_frame(6'd17, 32'h12345678));
      rd(4'd0, d); chk("R5 R6 cmd word after done", d, cw & 32'h7FFF);
      rd(4'd3, d); chk("R7 resp0 payload", d, 32'hCAFEF00D);
      rd(4'd7, d); chk("R7 status clean", d, 0);
   endtask

   task automatic t_crc_err();
      logic [47:0] fr;
      logic [31:0] d;
      exchange(32'h8000 | 32'd13, 32'hA5A5_0F0F, 1, 2, 48,
               {88'b0, short_rsp(6'd13, 32'h0000_0900) ^ 48'h2}, fr);
      wait_done();
      chk("R3 R4 frame cmd13", fr, cmd_frame(6'd13, 32'hA5A5_0F0F));
      rd(4'd7, d); chk("R7 crc status", d, 32'h10);
      rd(4'd0, d); chk("R7 failed bit", d[15:14], 2'b01);
      rd(4'd3, d); chk("R7 resp0 stored", d, 32'h0000_0900);
      wr(4'd7, 32'h30);
      rd(4'd7, d); chk("R11 crc cleared", d, 0);
   endtask

   task automatic t_long();
      logic [47:0] fr;
      logic [31:0] d;
      logic [127:0] pl = {32'h1111_2222, 32'h3333_4444, 32'h5555_6666, 32'h7777_8888};
      exchange(32'h8000 | (32'd1 << 9) | 32'd2, 32'h0, 1, 3, 136, {8'h3F, pl}, fr);
      wait_done();
      rd(4'd6, d); chk("R8 resp3", d, 32'h1111_2222);
      rd(4'd5, d); chk("R8 resp2", d, 32'h3333_4444);
      rd(4'd4, d); chk("R8 resp1", d, 32'h5555_6666);
      rd(4'd3, d); chk("R8 resp0", d, 32'h7777_8888);
      rd(4'd7, d); chk("R8 no crc check", d, 0);
   endtask

   task automatic t_none();
      logic [47:0] fr;
      logic [31:0] d;
      exchange(32'h8000 | (32'd2 << 9), 32'h0, 0, 0, 0, '0, fr);
      wait_done();
      chk("R3 R4 frame cmd0", fr, cmd_frame(6'd0, 32'h0));
      rd(4'd0, d); chk("R6 type2 done", d[15:14], 2'b00);
      rd(4'd7, d); chk("R6 type2 status", d, 0);
      exchange(32'h8000 | (32'd3 << 9) | 32'd5, 32'hFFFF_FFFF, 0, 0, 0, '0, fr);
      wait_done();
      chk("R3 R4 frame all ones arg", fr, cmd_frame(6'd5, 32'hFFFF_FFFF));
      rd(4'd7, d); chk("R6 type3 as none", d, 0);
      rd(4'd0, d); chk("R6 type3 done", d[15:14], 2'b00);
   endtask

   task automatic t_timeout();
      logic [47:0] fr;
      logic [31:0] d;
      exchange(32'h8000 | 32'd8, 32'h1AA, 1, 63, 48, {88'b0, short_rsp(6'd8, 32'h1AA)}, fr);
      wait_done();
      rd(4'd7, d); chk("R9 late start accepted", d, 0);
      rd(4'd3, d); chk("R9 late resp0", d, 32'h1AA);
      exchange(32'h8000 | 32'd9, 32'h0, 0, 0, 0, '0, fr);
      wait_done();
      rd(4'd7, d); chk("R9 timeout flag", d, 32'h40);
      rd(4'd0, d); chk("R9 failed set", d[15:14], 2'b01);
      wr(4'd7, 32'h0);
      rd(4'd7, d); chk("R11 zero write keeps", d, 32'h40);
      wr(4'd7, 32'h40);
      rd(4'd7, d); chk("R11 one write clears", d, 0);
      exchange(32'h8000 | (32'd2 << 9), 32'h0, 0, 0, 0, '0, fr);
      rd(4'd0, d); chk("R12 launch clears failed", d[14], 1'b0);
      wait_done();
   endtask

   task automatic t_busy();
      logic [47:0] fr;
      logic [31:0] d;
      wr(4'd8, 32'h404);
      chk("R12 bus_4bit slow_card", {bus_4bit, slow_card}, 2'b10);
      dat0_in = 1'b0;
      exchange(32'h8000 | (32'd4 << 9) | 32'd7, 32'h0001_0000, 1, 2, 48,
               {88'b0, short_rsp(6'd7, 32'h700)}, fr);
      repeat (20) @(negedge card_clk);
      rd(4'd0, d); chk("R10 holds while busy", d[15], 1'b1);
      rd(4'd7, d); chk("R10 no flag while busy", d, 0);
      chk("R10 irq low while busy", irq, 1'b0);
      wr(4'd1, 32'hDEAD);
      wr(4'd0, 32'h800C);
      dat0_in = 1'b1;
      wait_done();
      rd(4'd7, d); chk("R10 busy flag", d, 32'h400);
      chk("R10 irq enabled", irq, 1'b1);
      rd(4'd1, d); chk("R5 arg write ignored", d, 32'h0001_0000);
      rd(4'd0, d); chk("R5 cmd write ignored", d[11:0], 12'h807);
      wr(4'd7, 32'h400);
      chk("R11 R10 irq cleared", irq, 1'b0);
      wr(4'd8, 32'h8);
      chk("R12 slow_card", {bus_4bit, slow_card}, 2'b01);
      dat0_in = 1'b0;
      exchange(32'h8000 | (32'd4 << 9) | 32'd12, 32'h0, 1, 1, 48,
               {88'b0, short_rsp(6'd12, 32'h0)}, fr);
      repeat (4) @(negedge card_clk);
      dat0_in = 1'b1;
      wait_done();
      rd(4'd7, d); chk("R10 flag without enable", d, 32'h400);
      chk("R10 irq gated", irq, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_clock();
      t_short();
      t_crc_err();
      t_long();
      t_none();
      t_timeout();
      t_busy();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      #(4 * 150000);
      nchk++;
      nfail++;
      $display("FAIL watchdog R1-all actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule